// File: doc/BRIEF.md
# Register File with Write Protection for Control Entries

This block is a sixteen-entry, 32-bit register file for a processor core. It has two read ports and one write port. The read ports are combinational: a read address selects a value in the same cycle. The write port is synchronous and updates the addressed entry at the rising clock edge. Entry 0 is a constant zero. General-purpose entries 1 to 12 can be written in any mode.

The three top entries hold control state: a pointer, an interrupt table base and a control word. Either privilege level may read them. Only privileged code may change them. The core supplies its current privilege level on a plain input. If a write reaches a control entry while that input says user mode, the write is dropped and a protection-fault strobe rises in the same cycle. The surrounding core turns that strobe into an exception.

All pins are plain control and data wires. The write is a single-cycle command with no handshake, so the block never stalls the core and never applies back-pressure.

Top module: `priv_regfile`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears every entry to zero, including the control entries. The fault strobe is low while rst is high.
- R2: With wr_en high and the write allowed, the rising edge stores wr_data at wr_addr. The new value is visible on both read ports from the next cycle.
- R3: Address 0 always reads 32'h0 on both ports. A write to address 0 changes nothing and raises no fault.
- R4: The two read ports select independently. rd_data_a always shows the entry at rd_addr_a, and rd_data_b always shows the entry at rd_addr_b, for every pair of addresses.
- R5: A read of an entry that is being written in the same cycle returns the value held before the edge.
- R6: When priv_mode is 1 (privileged), a write to addresses 13, 14 or 15 is stored like any other write.
- R7: When priv_mode is 0 (user), a write to addresses 13, 14 or 15 is blocked, and every entry keeps its value.
- R8: gp_fault is high in exactly the cycles where wr_en is 1, priv_mode is 0, wr_addr is 13, 14 or 15, and rst is 0. It is combinational, so it coincides with the blocked write.
- R9: Control entries 13 to 15 can be read in both privilege modes.
- R10: While wr_en is 0, no entry changes, whatever the other write inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| priv_mode | input | 1 | Current privilege level: 1 privileged, 0 user |
| wr_en | input | 1 | Write command for this cycle |
| wr_addr | input | 4 | Entry to write |
| wr_data | input | 32 | Value to write |
| rd_addr_a | input | 4 | Read address, port A |
| rd_data_a | output | 32 | Read data, port A (combinational) |
| rd_addr_b | input | 4 | Read address, port B |
| rd_data_b | output | 32 | Read data, port B (combinational) |
| gp_fault | output | 1 | Protection fault strobe for a blocked write |

## Verification
A corrupted entry becomes visible on a read port in the first cycle after the bad edge. The bench therefore reads back every entry on both ports, over all 256 address pairs, after each write sweep. A permission decision that goes the wrong way shows in two places in the same cycle: the fault strobe disagrees with the expected value, and on the next cycle a control entry reads a value it should not hold. Stale-read and write-through errors show during the write cycle itself, because the bench reads the target entry while the write is pending.

// File: rtl/prf_pkg.sv
package prf_pkg;
  parameter int PRF_ENTRIES   = 16;
  parameter int PRF_WIDTH     = 32;
  parameter int PRF_CTRL_BASE = 13;

  typedef enum logic {
    MODE_USER = 1'b0,
    MODE_PRIV = 1'b1
  } prf_mode_e;
endpackage

// File: rtl/prf_write_guard.sv
module prf_write_guard
  import prf_pkg::*;
#(
  parameter int ENTRIES   = PRF_ENTRIES,
  parameter int CTRL_BASE = PRF_CTRL_BASE,
  localparam int AW       = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          priv_mode,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  output logic          commit_o,
  output logic          fault_o
);
  logic      is_ctrl;
  logic      is_zero;
  prf_mode_e mode;

  always_comb begin
    mode    = prf_mode_e'(priv_mode);
    is_ctrl = (wr_addr >= AW'(CTRL_BASE));
    is_zero = (wr_addr == '0);
  end

  // Work out whether the requested write may go ahead.
  always_comb begin
    commit_o = 1'b0;
    fault_o  = 1'b0;
    if (!rst && wr_en) begin
      if (is_ctrl && mode == MODE_USER) begin
        fault_o = 1'b1;
      end else if (!is_zero) begin
        commit_o = 1'b1;
      end
    end
  end

  // R8: a fault only comes from a user-mode write.
  p_fault_user_only_r8: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> (wr_en && priv_mode == 1'b0));
  // R7: a blocked write never commits.
  p_fault_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> !commit_o);
endmodule

// File: rtl/prf_storage.sv
module prf_storage
  import prf_pkg::*;
#(
  parameter int ENTRIES = PRF_ENTRIES,
  parameter int WIDTH   = PRF_WIDTH,
  localparam int AW     = $clog2(ENTRIES)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          commit,
  input  logic [AW-1:0]                 wr_addr,
  input  logic [WIDTH-1:0]              wr_data,
  output logic [ENTRIES-1:0][WIDTH-1:0] regs_q
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    if (i == 0) begin : g_zero
      assign regs_q[i] = '0;
    end else begin : g_reg
      logic [WIDTH-1:0] ent_q;
      always_ff @(posedge clk) begin
        if (rst)                                 ent_q <= '0;
        else if (commit && wr_addr == AW'(i))    ent_q <= wr_data;
      end
      assign regs_q[i] = ent_q;
    end
  end

  // R1: the reset clears the whole file.
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> regs_q == '0);
  // R2: a committed write lands in the addressed entry.
  p_commit_lands_r2: assert property (@(posedge clk) disable iff (rst)
    commit |=> regs_q[$past(wr_addr)] == $past(wr_data));
  // R10: without a commit, the file holds its contents.
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!commit && !rst) |=> regs_q == $past(regs_q));
endmodule

// File: rtl/prf_read_port.sv
module prf_read_port
  import prf_pkg::*;
#(
  parameter int ENTRIES = PRF_ENTRIES,
  parameter int WIDTH   = PRF_WIDTH,
  localparam int AW     = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0][WIDTH-1:0] regs,
  input  logic [AW-1:0]                 addr,
  output logic [WIDTH-1:0]              data
);
  always_comb begin
    if (addr == '0) data = '0;
    else            data = regs[addr];
  end
endmodule

// File: rtl/priv_regfile.sv
module priv_regfile
  import prf_pkg::*;
#(
  parameter int ENTRIES   = PRF_ENTRIES,
  parameter int WIDTH     = PRF_WIDTH,
  parameter int CTRL_BASE = PRF_CTRL_BASE,
  localparam int AW       = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             priv_mode,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr_a,
  output logic [WIDTH-1:0] rd_data_a,
  input  logic [AW-1:0]    rd_addr_b,
  output logic [WIDTH-1:0] rd_data_b,
  output logic             gp_fault
);
  localparam int NRD = 2;

  logic                          commit;
  logic [ENTRIES-1:0][WIDTH-1:0] regs;
  logic [NRD-1:0][AW-1:0]        rd_addr;
  logic [NRD-1:0][WIDTH-1:0]     rd_data;

  prf_write_guard #(.ENTRIES(ENTRIES), .CTRL_BASE(CTRL_BASE)) u_guard (
    .clk(clk), .rst(rst), .priv_mode(priv_mode), .wr_en(wr_en),
    .wr_addr(wr_addr), .commit_o(commit), .fault_o(gp_fault)
  );

  prf_storage #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_store (
    .clk(clk), .rst(rst), .commit(commit), .wr_addr(wr_addr),
    .wr_data(wr_data), .regs_q(regs)
  );

  assign rd_addr[0] = rd_addr_a;
  assign rd_addr[1] = rd_addr_b;

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    prf_read_port #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_rd (
      .regs(regs), .addr(rd_addr[p]), .data(rd_data[p])
    );
  end

  assign rd_data_a = rd_data[0];
  assign rd_data_b = rd_data[1];

  // R3: address zero reads zero on both ports.
  p_zero_read_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_a == '0 |-> rd_data_a == '0) and (rd_addr_b == '0 |-> rd_data_b == '0));
  // R7: after a fault, the targeted control entry is unchanged.
  p_ctrl_kept_r7: assert property (@(posedge clk) disable iff (rst)
    gp_fault |=> regs[$past(wr_addr)] == $past(regs[wr_addr]));
endmodule

// File: tb/sim_priv_regfile.sv
module sim_priv_regfile;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        priv_mode = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr_a = '0;
  logic [3:0]  rd_addr_b = '0;
  logic [31:0] rd_data_a, rd_data_b;
  logic        gp_fault;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] m [16];

  always #(CLK_P/2) clk = ~clk;

  priv_regfile u0 (
    .clk(clk), .rst(rst), .priv_mode(priv_mode), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr_a(rd_addr_a),
    .rd_data_a(rd_data_a), .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .gp_fault(gp_fault)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(int i, bit inv);
    logic [31:0] v;
    v = 32'h3C00_0000 + 32'(i) * 32'h0101_0107;
    return inv ? ~v : v;
  endfunction

  task automatic read_all(string req);
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        @(negedge clk);
        rd_addr_a = 4'(a);
        rd_addr_b = 4'(b);
        #1;
        check(req, rd_data_a, m[a]);
        check(req, rd_data_b, m[b]);
      end
    end
  endtask

  task automatic do_write(int a, logic [31:0] d, bit pm);
    bit blocked;
    blocked = (pm == 1'b0) && (a >= 13);
    @(negedge clk);
    priv_mode = pm; wr_en = 1'b1; wr_addr = 4'(a); wr_data = d; rd_addr_a = 4'(a);
    #1;
    check("R8 fault strobe", {31'b0, gp_fault}, {31'b0, blocked});
    check("R5 old value during write", rd_data_a, m[a]);
    @(posedge clk);
    if (!blocked && a != 0) m[a] = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    check(blocked ? "R7 blocked write" : (a == 0 ? "R3 zero write" : "R2 R6 write lands"),
          rd_data_a, m[a]);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) m[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    read_all("R1 reset state");

    for (int i = 0; i < 16; i++) do_write(i, pat(i, 0), 1'b1);
    read_all("R4 R9 privileged readback");

    for (int i = 0; i < 16; i++) do_write(i, pat(i, 1), 1'b0);
    priv_mode = 1'b0;
    read_all("R7 R9 user readback");

    @(negedge clk);
    priv_mode = 1'b0; wr_en = 1'b0; wr_addr = 4'd14; wr_data = 32'hDEAD_BEEF;
    #1;
    check("R8 no fault when idle", {31'b0, gp_fault}, 32'h0);
    @(negedge clk);
    priv_mode = 1'b1; wr_addr = 4'd5;
    @(negedge clk);
    rd_addr_a = 4'd14; rd_addr_b = 4'd5;
    #1;
    check("R10 idle hold", rd_data_a, m[14]);
    check("R10 idle hold", rd_data_b, m[5]);

    @(negedge clk);
    rst = 1'b1; priv_mode = 1'b0; wr_en = 1'b1; wr_addr = 4'd13;
    #1;
    check("R1 fault masked in reset", {31'b0, gp_fault}, 32'h0);
    @(negedge clk);
    wr_en = 1'b0; rst = 1'b0;
    for (int i = 0; i < 16; i++) m[i] = '0;
    read_all("R1 reset clears");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule